// File: doc/BRIEF.md
# Peak-and-Hold Solenoid Gate Controller

This block drives the gate of the external switch that feeds a solenoid coil. When its enable input goes high, it first regulates the coil current against a high "peak" reference. This gives the armature a strong pull-in. After a programmable number of clock cycles it drops to a lower "hold" reference, which keeps the armature seated with less dissipation. The hold level stays in force until enable falls. The gate is then forced low and the coil current decays. Analog sensing, the comparator, the reference DAC and the gate driver all sit outside the block.

Regulation runs cycle by cycle. A free-running PWM tick opens the gate. A comparator flag, which reports that the sensed current is above the selected reference, closes it again. The gate is held open for a programmable minimum on-time after every tick, whatever the comparator reports. The block outputs the reference code the DAC should present. Peak and hold codes are each clamped to their own defaults when they exceed their own limits.

The block has two state machines. The phase machine has the states IDLE, PEAK and HOLD, with these transitions:
- IDLE to PEAK when enable is high.
- PEAK to HOLD when the keep count has expired.
- Any state to IDLE when enable is low.

The gate machine has the states OFF, WAIT, MIN and REG, with these transitions:
- OFF to WAIT when enabled without a tick.
- OFF or WAIT to MIN on an enabled tick, or to REG on an enabled tick when the minimum on-time is zero.
- MIN to REG when the minimum count is spent and the comparator is low.
- MIN to WAIT when the minimum count is spent and the comparator is high.
- REG to WAIT when the comparator is high.
- MIN or REG back to MIN on a new tick (restart).
- Any state to OFF when enable is low.

Top module: `sol_peak_hold_ctrl`

## Requirements
- R1: After reset, gate is 0, phase is 0 (idle) and ref_code is 0.
- R2: In the cycle after enable is seen high in idle, phase becomes 1 (peak) and ref_code equals the clamped peak code.
- R3: With keep_cycles = K captured on entry to peak, phase stays 1 for K+1 cycles and then becomes 2 (hold), where ref_code equals the clamped hold code. Changes to keep_cycles during peak have no effect.
- R4: Phase 2 (hold) persists for as long as enable stays high.
- R5: One cycle after enable is seen low, gate is 0, phase is 0 and ref_code is 0. PWM ticks while disabled leave gate at 0. Re-enabling restarts from phase 1.
- R6: An enabled pwm_tick raises gate from the following cycle. Gate never rises without a tick in the previous cycle.
- R7: While enabled, gate stays high as long as the comparator is low. A rising comparator is passed through a two-flop synchronizer, so gate falls on the third clock edge after the change. Gate then stays low until the next tick.
- R8: After a tick, gate stays high for at least max(M,1) cycles (M = min_on_cycles) whatever the comparator reports. A tick during an ON-cycle restarts the minimum count, so an M longer than the tick period keeps gate high.
- R9: A peak code above 200 is replaced by 180. A hold code above 33 is replaced by 30 (one sixth of 180). Codes at or below their limit pass unchanged, and the two clamps are independent.
- R10: The phase output encodes idle as 0, peak as 1 and hold as 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Activation request, synchronous to clk |
| cmp_above | input | 1 | Comparator flag, asynchronous: sensed current above reference |
| pwm_tick | input | 1 | One-cycle pulse that starts an ON-cycle |
| peak_code | input | 8 | Programmed peak reference code |
| hold_code | input | 8 | Programmed hold reference code |
| keep_cycles | input | 16 | Peak-phase length in cycles (latched on activation) |
| min_on_cycles | input | 8 | Minimum gate-high cycles per ON-cycle |
| gate | output | 1 | Switch gate drive |
| ref_code | output | 8 | Reference code for the external DAC |
| phase | output | 2 | 0 idle, 1 peak, 2 hold |

## Verification
The assertions assume that enable and pwm_tick are synchronous to clk and that pwm_tick is a single-cycle pulse. They also assume that the comparator only needs to be seen after its two-flop delay, so no property looks at the raw cmp_above. The bench changes every synchronous input at the falling edge and drives each tick as a one-cycle pulse. Before it relies on a comparator level, it holds that level for several cycles, so the synchronized value is settled. The one exception is the directed turn-off check, which counts the synchronizer delay explicitly.

// File: rtl/sol_pkg.sv
package sol_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PEAK = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        GS_OFF  = 2'd0,
        GS_WAIT = 2'd1,
        GS_MIN  = 2'd2,
        GS_REG  = 2'd3
    } gate_e;

endpackage

// File: rtl/sol_sync.sv
module sol_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '0;
                else        sh <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '0;
                else        sh <= {sh[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh[STAGES-1];
endmodule

// File: rtl/sol_ref_clamp.sv
module sol_ref_clamp #(
    parameter int CODE_W = 8,
    parameter int LIMIT  = 200,
    parameter int DEF    = 180
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] code_o
);
    localparam logic [CODE_W-1:0] LIMIT_C = CODE_W'(LIMIT);
    localparam logic [CODE_W-1:0] DEF_C   = CODE_W'(DEF);

    always_comb begin
        code_o = (code_i > LIMIT_C) ? DEF_C : code_i;
    end
endmodule

// File: rtl/sol_phase_fsm.sv
module sol_phase_fsm
    import sol_pkg::*;
#(
    parameter int KEEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [KEEP_W-1:0] keep_cycles,
    output phase_e            phase_o
);
    phase_e            st_q, st_d;
    logic [KEEP_W-1:0] keep_q;

    // next-state decode
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PH_IDLE: if (enable) st_d = PH_PEAK;
            PH_PEAK: begin
                if (!enable)          st_d = PH_IDLE;
                else if (keep_q == '0) st_d = PH_HOLD;
            end
            PH_HOLD: if (!enable) st_d = PH_IDLE;
            default: st_d = PH_IDLE;
        endcase
    end

    // state register and keep timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= PH_IDLE;
            keep_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == PH_IDLE && enable)
                keep_q <= keep_cycles;
            else if (st_q == PH_PEAK && keep_q != '0)
                keep_q <= keep_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        phase_o = st_q;
    end

    // an activation always enters through the peak phase
    p_enter_peak_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == PH_IDLE && st_q != PH_IDLE) |-> st_q == PH_PEAK);

    // hold remains while enable stays high
    p_hold_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_HOLD && enable) |=> st_q == PH_HOLD);

    // disable returns the phase to idle
    p_idle_on_disable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> st_q == PH_IDLE);
endmodule

// File: rtl/sol_gate_fsm.sv
module sol_gate_fsm
    import sol_pkg::*;
#(
    parameter int MINON_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               tick,
    input  logic               cmp_hi,
    input  logic [MINON_W-1:0] min_on,
    output logic               gate_o
);
    gate_e              st_q, st_d, start_st;
    logic [MINON_W-1:0] cnt_q;
    logic               start;

    assign start    = enable & tick;
    assign start_st = (min_on == '0) ? GS_REG : GS_MIN;

    // next-state decode
    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d = GS_OFF;
        end else begin
            unique case (st_q)
                GS_OFF:  st_d = start ? start_st : GS_WAIT;
                GS_WAIT: if (start) st_d = start_st;
                GS_MIN: begin
                    if (start)             st_d = start_st;
                    else if (cnt_q == '0)  st_d = cmp_hi ? GS_WAIT : GS_REG;
                end
                GS_REG: begin
                    if (start)       st_d = start_st;
                    else if (cmp_hi) st_d = GS_WAIT;
                end
                default: st_d = GS_OFF;
            endcase
        end
    end

    // state register and minimum on-time counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= GS_OFF;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (start)
                cnt_q <= (min_on == '0) ? '0 : min_on - 1'b1;
            else if (st_q == GS_MIN && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        gate_o = (st_q == GS_MIN) || (st_q == GS_REG);
    end

    p_gate_low_after_disable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !gate_o);

    p_gate_rise_needs_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(tick));

    p_min_on_holds_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == GS_MIN && cnt_q != '0 && enable) |=> gate_o);

    p_wait_stays_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == GS_WAIT && !tick) |=> !gate_o);
endmodule

// File: rtl/sol_peak_hold_ctrl.sv
module sol_peak_hold_ctrl
    import sol_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int KEEP_W      = 16,
    parameter int MINON_W     = 8,
    parameter int SYNC_STAGES = 2,
    parameter int PEAK_MAX    = 200,
    parameter int PEAK_DEF    = 180
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               cmp_above,
    input  logic               pwm_tick,
    input  logic [CODE_W-1:0]  peak_code,
    input  logic [CODE_W-1:0]  hold_code,
    input  logic [KEEP_W-1:0]  keep_cycles,
    input  logic [MINON_W-1:0] min_on_cycles,
    output logic               gate,
    output logic [CODE_W-1:0]  ref_code,
    output logic [1:0]         phase
);
    localparam int HOLD_MAX = PEAK_MAX / 6;
    localparam int HOLD_DEF = PEAK_DEF / 6;

    phase_e            ph;
    logic              cmp_s;
    logic [CODE_W-1:0] peak_c, hold_c;

    sol_sync #(.STAGES(SYNC_STAGES)) u_cmp_sync (
        .clk(clk), .rst_n(rst_n), .d(cmp_above), .q(cmp_s)
    );

    sol_ref_clamp #(.CODE_W(CODE_W), .LIMIT(PEAK_MAX), .DEF(PEAK_DEF)) u_peak_clamp (
        .code_i(peak_code), .code_o(peak_c)
    );

    sol_ref_clamp #(.CODE_W(CODE_W), .LIMIT(HOLD_MAX), .DEF(HOLD_DEF)) u_hold_clamp (
        .code_i(hold_code), .code_o(hold_c)
    );

    sol_phase_fsm #(.KEEP_W(KEEP_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .keep_cycles(keep_cycles), .phase_o(ph)
    );

    sol_gate_fsm #(.MINON_W(MINON_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(pwm_tick),
        .cmp_hi(cmp_s), .min_on(min_on_cycles), .gate_o(gate)
    );

    // reference selection by phase
    always_comb begin
        unique case (ph)
            PH_PEAK: ref_code = peak_c;
            PH_HOLD: ref_code = hold_c;
            default: ref_code = '0;
        endcase
        phase = ph;
    end

    p_ref_within_peak_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1) |-> (ref_code <= CODE_W'(PEAK_MAX)));

    p_ref_within_hold_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2) |-> (ref_code <= CODE_W'(HOLD_MAX)));

    p_phase_code_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 2'd3);
endmodule

// File: tb/sol_peak_hold_ctrl_tb.sv
module sol_peak_hold_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       cmp_above = 1'b1;
    logic       pwm_tick = 1'b0;
    logic [7:0] peak_code = 8'd150;
    logic [7:0] hold_code = 8'd25;
    logic [15:0] keep_cycles = 16'd4;
    logic [7:0] min_on_cycles = 8'd2;
    logic       gate;
    logic [7:0] ref_code;
    logic [1:0] phase;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sol_peak_hold_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cmp_above(cmp_above),
        .pwm_tick(pwm_tick), .peak_code(peak_code), .hold_code(hold_code),
        .keep_cycles(keep_cycles), .min_on_cycles(min_on_cycles),
        .gate(gate), .ref_code(ref_code), .phase(phase)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) pwm_tick = 1'b1;
        @(negedge clk) pwm_tick = 1'b0;
    endtask

    task automatic count_high(output int n);
        n = 0;
        while (gate === 1'b1 && n < 400) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1 gate", gate, 0);
        chk("R1 phase", phase, 0);
        chk("R1 ref", ref_code, 0);
    endtask

    task automatic t_peak_hold();
        @(negedge clk) enable = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (i == 1) begin
                chk("R2 phase", phase, 1);
                chk("R2 ref", ref_code, 150);
                chk("R10 peak code", phase, 1);
                keep_cycles = 16'd0;
            end
            if (i == 5) chk("R3 still peak at K+1", phase, 1);
            if (i == 6) begin
                chk("R3 hold after K+1", phase, 2);
                chk("R3 hold ref", ref_code, 25);
            end
        end
        repeat (50) @(negedge clk);
        chk("R4 hold persists", phase, 2);
    endtask

    task automatic t_regulate();
        int bad = 0;
        cmp_above = 1'b0;
        min_on_cycles = 8'd2;
        repeat (4) @(negedge clk);
        pulse_tick();
        chk("R6 gate after tick", gate, 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (gate !== 1'b1) bad++;
        end
        chk("R7 high while cmp low", bad, 0);
        cmp_above = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R7 high during sync delay", gate, 1);
        @(negedge clk);
        chk("R7 low after sync", gate, 0);
        cmp_above = 1'b0;
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (gate !== 1'b0) bad++;
        end
        chk("R6 no rise without tick", bad, 0);
    endtask

    task automatic t_min_on();
        int n;
        cmp_above = 1'b1;
        repeat (4) @(negedge clk);
        min_on_cycles = 8'd5;
        pulse_tick();
        count_high(n);
        chk("R8 min on 5", n, 5);
        min_on_cycles = 8'd0;
        pulse_tick();
        count_high(n);
        chk("R8 min on 0", n, 1);
        min_on_cycles = 8'd1;
        pulse_tick();
        count_high(n);
        chk("R8 min on 1", n, 1);
    endtask

    task automatic t_restart();
        int lows = 0;
        min_on_cycles = 8'd200;
        pulse_tick();
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 14; i++) begin
                @(negedge clk);
                if (gate !== 1'b1) lows++;
            end
            pulse_tick();
        end
        chk("R8 restart keeps gate high", lows, 0);
    endtask

    task automatic t_disable();
        int bad = 0;
        @(negedge clk) enable = 1'b0;
        @(negedge clk);
        chk("R5 gate low", gate, 0);
        chk("R5 phase idle", phase, 0);
        chk("R5 ref zero", ref_code, 0);
        cmp_above = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            pulse_tick();
            if (gate !== 1'b0) bad++;
        end
        chk("R5 ticks ignored", bad, 0);
        keep_cycles = 16'd0;
        peak_code = 8'd201;
        hold_code = 8'd40;
        @(negedge clk) enable = 1'b1;
        @(negedge clk);
        chk("R5 restart at peak", phase, 1);
        chk("R9 peak clamp 201", ref_code, 180);
        peak_code = 8'd200;
        #1 chk("R9 peak at limit", ref_code, 200);
        @(negedge clk);
        chk("R10 hold code", phase, 2);
        chk("R9 hold clamp 40", ref_code, 30);
        hold_code = 8'd33;
        peak_code = 8'd255;
        #1 chk("R9 hold at limit independent", ref_code, 33);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_peak_hold();
        t_regulate();
        t_min_on();
        t_restart();
        t_disable();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule